// File: doc/BRIEF.md
# Wide-Range Programmable Integer Clock Divider

This block turns a fast input clock into a slower one. The division ratio N is an unsigned binary word. The output is registered and contains only whole input cycles. Every output period lasts exactly N input cycles. The high phase is floor(N/2) cycles, which gives an exact 50% duty cycle for even ratios. For odd ratios the duty cycle comes as near to 50% as rising-edge-only logic allows, and it gets closer as N grows. Because the duty cycle depends only on N, it does not change with the input clock frequency.

A new ratio is presented on the ratio input together with a one-cycle load strobe. The block holds the new value and applies it only when the next output period begins. As a result, a ratio change never shortens or stretches a pulse that is already running. A one-cycle flag marks the first input cycle of every output period. Downstream logic can use this flag to stay aligned with the divided clock.

Top module: `wide_clkdiv`

## Requirements
- R1: The ratio is an unsigned binary word of W bits (W = 19 gives ratios 8 through 524287). A loaded value from 0 to 7 is treated as 8.
- R2: For an even ratio N, the output is high for exactly N/2 input cycles and then low for N/2 input cycles.
- R3: For an odd ratio N, the output is high for (N-1)/2 input cycles and low for (N+1)/2 input cycles. For example, N = 9 gives 4 cycles high and 5 cycles low.
- R4: Consecutive period starts are exactly N input cycles apart, where N is the ratio in force for that period.
- R5: A ratio captured by the load strobe leaves the current period unchanged. It governs the first period that begins on a later clock edge. A load captured on the same edge that begins a period therefore applies one period later.
- R6: While reset is high, the output and the period-start flag are low and the ratio in force is 8. The first clock edge after reset is released begins a new period, with the output going high.
- R7: The period-start flag is high for exactly one input cycle. That cycle is the first cycle of each period, in which the registered output has just gone high.
- R8: If several loads occur before the next period begins, the most recent value is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_in | input | W | Requested division ratio, unsigned binary |
| ratio_load | input | 1 | Captures ratio_in on a rising clock edge |
| div_out | output | 1 | Registered divided clock |
| period_start | output | 1 | One-cycle pulse in the first cycle of each output period |

## Verification
The bench builds the divider with W = 12. This keeps the full ratio span, including the all-ones maximum of 4095, short enough that whole periods fit well within the run budget. At that width the bench measures the high time and the period, cycle by cycle, for ratios 8, 9, 10, 11, 1000, 1001 and 4095, and for the clamped inputs 3 and 0. The same narrow build also covers the mid-period, same-edge and repeated load cases. The counter logic does not depend on W, so the 19-bit default behaves the same way over its larger range.

// File: rtl/wide_clkdiv.sv
module wide_clkdiv #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio_in,
  input  logic         ratio_load,
  output logic         div_out,
  output logic         period_start
);

  localparam logic [W-1:0] N_MIN = W'(8);

  logic [W-1:0] n_act;
  logic [W-1:0] n_pend;
  logic [W-1:0] cnt;
  logic [W-1:0] half;
  logic [W-1:0] cnt_nxt;
  logic [W-1:0] in_fixed;
  logic         fresh;
  logic         wrap;

  assign in_fixed = (ratio_in < N_MIN) ? N_MIN : ratio_in;
  assign half     = n_act >> 1;
  assign cnt_nxt  = cnt + 1'b1;
  assign wrap     = fresh || (cnt_nxt == n_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_act        <= N_MIN;
      n_pend       <= N_MIN;
      cnt          <= '0;
      fresh        <= 1'b1;
      div_out      <= 1'b0;
      period_start <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (ratio_load)
        n_pend <= in_fixed;
      if (wrap) begin
        n_act        <= n_pend;
        cnt          <= '0;
        div_out      <= 1'b1;
        period_start <= 1'b1;
      end else begin
        cnt          <= cnt_nxt;
        div_out      <= (cnt_nxt < half);
        period_start <= 1'b0;
      end
    end
  end

  // R6: reset holds both outputs low
  a_r6_reset_quiet: assert property (@(posedge clk)
    rst |=> (!div_out && !period_start));

  // R7: a rising output always carries the start flag
  a_r7_rise_flagged: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |-> period_start);

  // R7: the start flag only appears with the output high
  a_r7_flag_high: assert property (@(posedge clk) disable iff (rst)
    period_start |-> div_out);

  // R7: the flag lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  // R5: the ratio in force changes only when a period begins
  a_r5_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
    !period_start |-> $stable(n_act));

  // R1: the ratio in force never drops below the floor
  a_r1_ratio_floor: assert property (@(posedge clk) disable iff (rst)
    n_act >= N_MIN);

  // R4: the phase counter stays inside the period
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt < n_act);

endmodule

// File: tb/wide_clkdiv_test.sv
module wide_clkdiv_test;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ratio_in = '0;
  logic         ratio_load = 1'b0;
  logic         div_out;
  logic         period_start;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  wide_clkdiv #(.W(W)) uut (
    .clk(clk), .rst(rst), .ratio_in(ratio_in), .ratio_load(ratio_load),
    .div_out(div_out), .period_start(period_start)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ratio_load = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 reset out", int'(div_out), 0);
    check("R6 reset flag", int'(period_start), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 first period out", int'(div_out), 1);
    check("R6 first period flag", int'(period_start), 1);
  endtask

  // Entered at a negedge where the period flag is high; leaves at the next one.
  task automatic run_period(input string req, input int exp_n,
                            input int ld_at, input int ld_val,
                            input int ld2_at, input int ld2_val);
    int hi = 0;
    int len = 0;
    int falls = 0;
    logic prev = 1'b1;
    check({req, " R7 flag at start"}, int'(period_start && div_out), 1);
    for (int i = 0; i < 6000; i++) begin
      if (i > 0 && period_start) break;
      if (div_out) hi++;
      if (prev && !div_out) falls++;
      prev = div_out;
      len++;
      ratio_load = 1'b0;
      if (i == ld_at)  begin ratio_in = W'(ld_val);  ratio_load = 1'b1; end
      if (i == ld2_at) begin ratio_in = W'(ld2_val); ratio_load = 1'b1; end
      @(negedge clk);
    end
    ratio_load = 1'b0;
    check({req, " R4 period"}, len, exp_n);
    check({req, (exp_n % 2 == 0) ? " R2 high time" : " R3 high time"}, hi, exp_n / 2);
    check({req, " single low phase"}, falls, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    do_reset();
    run_period("R6 default 8, R5 load 9 mid",  8, 2, 9, -1, 0);
    run_period("R3 ratio 9",                    9, 0, 10, -1, 0);
    run_period("R2 ratio 10",                  10, 4, 11, -1, 0);
    run_period("R3 ratio 11",                  11, 3, 1000, -1, 0);
    run_period("R2 ratio 1000",              1000, 500, 1001, -1, 0);
    run_period("R3 ratio 1001",              1001, 7, 4095, -1, 0);
    run_period("R1 max 4095",                4095, 1, 3, -1, 0);
    run_period("R1 clamp of 3",                 8, 1, 0, -1, 0);
    run_period("R1 zero as 8",                  8, 5, 10, -1, 0);
    run_period("R5 ratio 10, late load 12",    10, 9, 12, -1, 0);
    run_period("R5 late load deferred",        10, -1, 0, -1, 0);
    run_period("R8 ratio 12, two loads",       12, 1, 20, 5, 14);
    run_period("R8 last load wins",            14, -1, 0, -1, 0);
    do_reset();
    run_period("R6 ratio 8 after re-reset",     8, -1, 0, -1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule